// File: doc/BRIEF.md
# Multi-Width Shift and Rotate Unit

This block shifts or rotates one operand at one of four widths: 8, 16, 32 or 64 bits. A single request carries a size code, an operation code, the operand, a shift count and a carry flag. The block returns the result, with every bit above the selected width cleared, and an updated carry flag. It offers logical left and right shifts, an arithmetic right shift, plain rotates in both directions, and rotates in both directions through the carry flag.

The arithmetic is a single combinational layer with one slice per width. A generate loop builds the four slices and the size code picks which slice drives the output. A parameter adds an optional output register. When that register is present, a two-state output stage tracks whether the captured result is valid. In `ST_EMPTY`, no new result is held. In `ST_FULL`, a result was captured on the last edge. The transition `EMPTY->FULL` is taken when `in_valid` is high at a clock edge. The transition `FULL->EMPTY` is taken when `in_valid` is low. `FULL->FULL` and `EMPTY->EMPTY` cover back-to-back requests and idle cycles. The data registers load only when a request is accepted, so the last result stays visible until the next one arrives.

Top module: `shift_rotate_unit`

## Requirements
- R1: The size code selects the width: 2'b00 is 8 bits, 2'b01 is 16 bits, 2'b10 is 32 bits and 2'b11 is 64 bits. Operand bits above the selected width are ignored, and result bits above it are always zero.
- R2: Operation 3'b000 shifts left and fills with zeros. For a count from 1 to W, carry_out is the last bit shifted out, operand bit W-count. For a count above W, the result is zero and carry_out is 0.
- R3: Operation 3'b001 shifts right logically. For a count from 1 to W, carry_out is operand bit count-1. For a count above W, the result is zero and carry_out is 0.
- R4: Operation 3'b011 shifts right arithmetically and fills with bit W-1 of the selected width, not bit 63. For a count of W or more, every result bit equals that sign bit. For a count above W, carry_out also equals that sign bit.
- R5: Operation 3'b100 rotates left and operation 3'b101 rotates right, by the count modulo W. For both, carry_out equals carry_in.
- R6: Operation 3'b110 rotates left through carry. The ring has W+1 bits, with the carry above bit W-1, and the count is taken modulo W+1. The result is the low W bits of the rotated ring and carry_out is its top bit.
- R7: Operation 3'b111 rotates the same (W+1)-bit ring to the right, by the count modulo W+1.
- R8: For any shift or rotate with a count of zero, the result is the operand and carry_out equals carry_in.
- R9: Operation 3'b010 is unassigned. It sets illegal to 1, passes the operand through unchanged and returns carry_in as carry_out. Every other code sets illegal to 0.
- R10: With the output register enabled, the result of a request accepted while in_valid is high appears on the next clock edge, together with out_valid high. While in_valid is low, out_valid falls and result, carry_out and illegal hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request valid |
| size | input | 2 | Width code |
| op | input | 3 | Operation code |
| operand | input | 64 | Value to shift or rotate |
| count | input | 7 | Shift or rotate count |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Zero-extended result |
| carry_out | output | 1 | Updated carry flag |
| illegal | output | 1 | Unassigned operation code seen |

## Verification
Two things can happen in the same cycle: the carry input is consumed by the ring and a new carry is produced from the bit that leaves it. The same cycle can also wrap the count modulo W+1, so an off-by-one in either function is hidden unless both are exercised together. The sweep drives counts W, W+1 and W+2 through both ring rotates with each carry value. At those counts the ring must return the operand or move the carry exactly one place. A bit-by-bit step model in the bench judges every result and carry.

// File: rtl/sru_pkg.sv
package sru_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LONG = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        OP_SHL  = 3'b000,
        OP_SHR  = 3'b001,
        OP_RSVD = 3'b010,
        OP_SAR  = 3'b011,
        OP_ROTL = 3'b100,
        OP_ROTR = 3'b101,
        OP_RCL  = 3'b110,
        OP_RCR  = 3'b111
    } op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

    // Mask of the bits that belong to the selected width.
    function automatic logic [63:0] width_mask(input logic [1:0] sz);
        logic [63:0] m;
        unique case (sz)
            2'b00:   m = 64'h0000_0000_0000_00FF;
            2'b01:   m = 64'h0000_0000_0000_FFFF;
            2'b10:   m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sru_decode.sv
module sru_decode
    import sru_pkg::*;
(
    input  logic [2:0] op_code,
    output op_e        op_kind,
    output logic       op_bad
);
    always_comb begin
        op_kind = op_e'(op_code);
        op_bad  = 1'b0;
        unique case (op_kind)
            OP_RSVD: op_bad = 1'b1;
            default: op_bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/sru_slice.sv
module sru_slice
    import sru_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 7
) (
    input  op_e              op_kind,
    input  logic [W-1:0]     val,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout
);
    localparam logic [CNT_W-1:0] ROT_MOD  = CNT_W'(W);
    localparam logic [CNT_W-1:0] RING_MOD = CNT_W'(W + 1);

    logic [CNT_W-1:0] rot_k;
    logic [CNT_W-1:0] ring_k;
    logic             cnt_zero;

    logic [W:0]         shl_ext;
    logic [W:0]         shr_ext;
    logic signed [W:0]  sar_ext;
    logic [2*W-1:0]     rotl_ext;
    logic [2*W-1:0]     rotr_ext;
    logic [W:0]         ring;
    logic [2*W+1:0]     rcl_ext;
    logic [2*W+1:0]     rcr_ext;

    assign rot_k    = cnt % ROT_MOD;
    assign ring_k   = cnt % RING_MOD;
    assign cnt_zero = (cnt == '0);

    assign shl_ext  = {1'b0, val} << cnt;
    assign shr_ext  = {val, 1'b0} >> cnt;
    assign sar_ext  = $signed({val, 1'b0}) >>> cnt;
    assign rotl_ext = {val, val} << rot_k;
    assign rotr_ext = {val, val} >> rot_k;
    assign ring     = {cin, val};
    assign rcl_ext  = {ring, ring} << ring_k;
    assign rcr_ext  = {ring, ring} >> ring_k;

    always_comb begin
        res  = val;
        cout = cin;
        unique case (op_kind)
            OP_SHL: begin
                res  = shl_ext[W-1:0];
                cout = cnt_zero ? cin : shl_ext[W];
            end
            OP_SHR: begin
                res  = shr_ext[W:1];
                cout = cnt_zero ? cin : shr_ext[0];
            end
            OP_SAR: begin
                res  = sar_ext[W:1];
                cout = cnt_zero ? cin : sar_ext[0];
            end
            OP_ROTL: begin
                res  = rotl_ext[2*W-1:W];
                cout = cin;
            end
            OP_ROTR: begin
                res  = rotr_ext[W-1:0];
                cout = cin;
            end
            OP_RCL: begin
                res  = rcl_ext[2*W:W+1];
                cout = rcl_ext[2*W+1];
            end
            OP_RCR: begin
                res  = rcr_ext[W-1:0];
                cout = rcr_ext[W];
            end
            OP_RSVD: begin
                res  = val;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CNT_W   = 7,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       size,
    input  logic [2:0]       op,
    input  logic [XLEN-1:0]  operand,
    input  logic [CNT_W-1:0] count,
    input  logic             carry_in,
    output logic             out_valid,
    output logic [XLEN-1:0]  result,
    output logic             carry_out,
    output logic             illegal
);
    localparam int NSIZE = 4;

    op_e             op_kind;
    logic            op_bad;
    logic [XLEN-1:0] slice_res [NSIZE];
    logic            slice_cy  [NSIZE];
    logic [XLEN-1:0] comb_res;
    logic            comb_cy;

    sru_decode u_dec (
        .op_code (op),
        .op_kind (op_kind),
        .op_bad  (op_bad)
    );

    for (genvar g = 0; g < NSIZE; g++) begin : g_width
        localparam int SW = XLEN >> (NSIZE - 1 - g);
        logic [SW-1:0] s_res;
        logic          s_cy;
        sru_slice #(.W(SW), .CNT_W(CNT_W)) u_slice (
            .op_kind (op_kind),
            .val     (operand[SW-1:0]),
            .cnt     (count),
            .cin     (carry_in),
            .res     (s_res),
            .cout    (s_cy)
        );
        assign slice_res[g] = XLEN'(s_res);
        assign slice_cy[g]  = s_cy;
    end

    always_comb begin
        comb_res = slice_res[size];
        comb_cy  = slice_cy[size];
    end

    if (REG_OUT) begin : g_reg
        stage_e          state_q, state_d;
        logic [XLEN-1:0] res_q;
        logic            cy_q;
        logic            bad_q;

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
                ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= ST_EMPTY;
            else        state_q <= state_d;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
                cy_q  <= 1'b0;
                bad_q <= 1'b0;
            end else if (in_valid) begin
                res_q <= comb_res;
                cy_q  <= comb_cy;
                bad_q <= op_bad;
            end
        end

        assign out_valid = (state_q == ST_FULL);
        assign result    = res_q;
        assign carry_out = cy_q;
        assign illegal   = bad_q;

        assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ((result & ~width_mask($past(size))) == '0));

        assert_reserved_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && illegal) |->
                (result == ($past(operand) & width_mask($past(size)))
                 && carry_out == $past(carry_in)));

        assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(in_valid)) |-> (illegal == ($past(op) == 3'b010)));

        assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(count) == '0) |->
                (result == ($past(operand) & width_mask($past(size)))
                 && carry_out == $past(carry_in)));

        assert_plain_rot_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && ($past(op) == 3'b100 || $past(op) == 3'b101)) |->
                (carry_out == $past(carry_in)));

        assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid));

        assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(in_valid) |-> ($stable(result) && $stable(carry_out) && $stable(illegal)));
    end else begin : g_comb
        assign out_valid = in_valid;
        assign result    = comb_res;
        assign carry_out = comb_cy;
        assign illegal   = op_bad;
    end
endmodule

// File: tb/shift_rotate_unit_test.sv
module shift_rotate_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  size = '0;
    logic [2:0]  op = '0;
    logic [63:0] operand = '0;
    logic [6:0]  count = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        carry_out;
    logic        illegal;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    shift_rotate_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size(size), .op(op),
        .operand(operand), .count(count), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .carry_out(carry_out), .illegal(illegal)
    );

    // Step model: applies one single-bit move per unit of count.
    task automatic model(input logic [1:0] sz, input logic [2:0] o, input logic [63:0] a,
                         input logic c, input int n,
                         output logic [63:0] r, output logic co, output logic il);
        int w;
        logic [63:0] m, v;
        logic cy, t, s;
        w  = 8 << sz;
        m  = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        v  = a & m;
        cy = c;
        il = (o == 3'b010);
        for (int i = 0; i < n; i++) begin
            case (o)
                3'b000: begin cy = v[w-1]; v = (v << 1) & m; end
                3'b001: begin cy = v[0]; v = v >> 1; end
                3'b011: begin cy = v[0]; s = v[w-1]; v = (v >> 1) | (64'(s) << (w-1)); end
                3'b100: begin t = v[w-1]; v = ((v << 1) & m) | 64'(t); end
                3'b101: begin t = v[0]; v = (v >> 1) | (64'(t) << (w-1)); end
                3'b110: begin t = v[w-1]; v = ((v << 1) & m) | 64'(cy); cy = t; end
                3'b111: begin t = v[0]; v = (v >> 1) | (64'(cy) << (w-1)); cy = t; end
                default: ;
            endcase
        end
        r  = v;
        co = cy;
    endtask

    function automatic string tag_of(input logic [2:0] o, input int n);
        if (o == 3'b010) return "R9";
        if (n == 0)      return "R8";
        case (o)
            3'b000:  return "R2";
            3'b001:  return "R3";
            3'b011:  return "R4";
            3'b100, 3'b101: return "R5";
            3'b110:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] got_r, input logic [63:0] exp_r,
                         input logic got_c, input logic exp_c, input logic got_i, input logic exp_i);
        total++;
        if (got_r !== exp_r || got_c !== exp_c || got_i !== exp_i) begin
            bad++;
            $display("FAIL %s: result=%h carry=%b illegal=%b expected result=%h carry=%b illegal=%b (size=%0d op=%0d cnt=%0d)",
                     tag, got_r, got_c, got_i, exp_r, exp_c, exp_i, size, op, count);
        end
    endtask

    task automatic run_one(input logic [1:0] sz, input logic [2:0] o, input logic [63:0] a,
                           input logic c, input int n);
        logic [63:0] er;
        logic ec, ei;
        @(negedge clk);
        in_valid = 1'b1; size = sz; op = o; operand = a; count = 7'(n); carry_in = c;
        model(sz, o, a, c, n, er, ec, ei);
        @(negedge clk);
        check(tag_of(o, n), result, er, carry_out, ec, illegal, ei);
        // R1: no bit above the selected width
        total++;
        if ((result >> (8 << sz)) != 64'd0 && sz != 2'b11) begin
            bad++;
            $display("FAIL R1: result=%h has bits above width %0d, expected zero", result, 8 << sz);
        end
        // R10: valid one cycle after acceptance
        total++;
        if (out_valid !== 1'b1) begin
            bad++;
            $display("FAIL R10: out_valid=%b expected 1", out_valid);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] pats [3];
        logic [63:0] held_r;
        logic held_c, held_i;
        pats[0] = 64'h8123_4567_89AB_CDEF;
        pats[1] = 64'h5A3C_7E01_6C0F_7155;
        pats[2] = 64'hC3FF_0000_00FF_80FE;

        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || result !== 64'd0 || carry_out !== 1'b0 || illegal !== 1'b0) begin
            bad++;
            $display("FAIL R10: reset outputs valid=%b result=%h carry=%b illegal=%b expected 0 0 0 0",
                     out_valid, result, carry_out, illegal);
        end
        rst_n = 1'b1;

        for (int sz = 0; sz < 4; sz++) begin
            for (int o = 0; o < 8; o++) begin
                for (int p = 0; p < 3; p++) begin
                    for (int c = 0; c < 2; c++) begin
                        for (int n = 0; n <= (8 << sz) + 2; n++)
                            run_one(2'(sz), 3'(o), pats[p], 1'(c), n);
                        run_one(2'(sz), 3'(o), pats[p], 1'(c), 127);
                    end
                end
            end
        end

        // R10: idle cycle holds outputs and drops valid
        @(negedge clk);
        held_r = result; held_c = carry_out; held_i = illegal;
        in_valid = 1'b0; op = 3'b010; operand = ~operand; carry_in = ~carry_in; count = 7'd3;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || result !== held_r || carry_out !== held_c || illegal !== held_i) begin
            bad++;
            $display("FAIL R10: idle valid=%b result=%h carry=%b illegal=%b expected 0 %h %b %b",
                     out_valid, result, carry_out, illegal, held_r, held_c, held_i);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule